// File: doc/BRIEF.md
# Dual-Slot Macro Execution ALU

This block is the arithmetic core of a small command-macro processor. Each issued instruction holds two ALU slots. Each slot names an operation, two source selectors and a destination register, and carries a 16-bit immediate of its own. Both slots are evaluated in the same cycle. Each result is written to the register file and is also held on a result output until the next issue. Branch, loop and state-read operations are decoded by other logic and do not reach this unit.

A single 32-bit carry register links the slots. It holds the carry or borrow bit of an add or subtract, or the upper word of a multiply. A carry that slot 0 produces is visible to slot 1 in the same instruction, so a 64-bit add, a 64-bit subtract or a multiply with its high word takes one instruction. Apart from that carry, both slots see the register state from before the instruction.

Top module: `dual_slot_alu`

## Requirements
- R1: After reset, `res0`, `res1` and `carry` are zero and every general register reads back as zero.
- R2: Op 0 (add) returns x+y and sets `carry` to 1 on unsigned overflow, otherwise 0. Op 2 (subtract) returns x−y and sets `carry` to 1 when y > x unsigned, otherwise 0. When both slots write the carry in one instruction, the value from slot 1 is kept.
- R3: Op 1 (add with carry) and op 3 (subtract with borrow) are issued only in slot 1, paired with op 0 or op 2 in slot 0. They return x+y+c or x−y−c, where c is the carry that slot 0 produced in the same instruction. They leave `carry` as slot 0 set it.
- R4: Op 4 (signed multiply) and op 6 (unsigned multiply) return the low 32 bits of the 64-bit product and put the high 32 bits in `carry`. Op 5 returns the carry value as it stands, and a slot 1 op 5 sees the high word that slot 0 produced in the same instruction.
- R5: Op 8 (shift left), op 9 (logical shift right) and op 10 (arithmetic shift right) use only bits 4:0 of y as the shift amount.
- R6: Op 11 returns AND, op 12 NAND, op 13 OR and op 14 XOR. Op 7 returns the count of leading zeros of x, and 32 when x is zero.
- R7: Op 15 (merge) decodes the slot's own immediate as follows: bits 15:10 give the destination position d, bits 9:5 give the width w and bits 4:0 give the source position s. It returns x with bits d..d+w−1 replaced by bits s..s+w−1 of y. Any bits placed above bit 31 are dropped.
- R8: Op 16 (signed <), op 17 (unsigned <), op 18 (signed ≤), op 19 (unsigned ≤) and op 20 (equal) return all ones when the comparison holds and zero when it does not.
- R9: Source codes 0..23 select a general register. Code 24 selects zero. Code 25 selects the slot's own immediate, sign-extended. Code 26 selects the other slot's immediate, sign-extended. Code 27 selects {imm0, imm1}. Code 28 selects `load0` and code 29 selects `load1`.
- R10: Both slots read their sources before either slot writes back. When both slots name the same destination register, slot 1's result is stored.
- R11: A destination code of 24 or above writes no register.
- R12: While `issue` is low, `res0`, `res1`, `carry` and all registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Execute the presented instruction at this edge |
| op0 | input | 5 | Slot 0 operation code |
| src0_a | input | 5 | Slot 0 x-source selector |
| src0_b | input | 5 | Slot 0 y-source selector |
| dst0 | input | 5 | Slot 0 destination code |
| op1 | input | 5 | Slot 1 operation code |
| src1_a | input | 5 | Slot 1 x-source selector |
| src1_b | input | 5 | Slot 1 y-source selector |
| dst1 | input | 5 | Slot 1 destination code |
| imm0 | input | 16 | Slot 0 immediate |
| imm1 | input | 16 | Slot 1 immediate |
| load0 | input | 32 | First parameter load value |
| load1 | input | 32 | Second parameter load value |
| res0 | output | 32 | Slot 0 result of the last issued instruction |
| res1 | output | 32 | Slot 1 result of the last issued instruction |
| carry | output | 32 | Shared carry / high-word register |

## Verification
The hardest case to reach is slot 1 consuming state that slot 0 creates in the same cycle. This happens in two places: the carry chain into add-with-carry, subtract-with-borrow and the high-word read, and the ordering of register reads against writes. Both appear only under specific slot pairings. The stimulus sweeps operand pairs at the 32-bit boundaries through paired add/add-with-carry, subtract/subtract-with-borrow and multiply/high-word instructions. It then swaps two registers in one instruction and sends both slots to one destination, and reads the whole register file back through ordinary instructions.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

   typedef enum logic [4:0] {
      OP_ADD   = 5'd0,
      OP_ADDC  = 5'd1,
      OP_SUB   = 5'd2,
      OP_SUBB  = 5'd3,
      OP_MUL   = 5'd4,
      OP_MULH  = 5'd5,
      OP_MULU  = 5'd6,
      OP_CLZ   = 5'd7,
      OP_SLL   = 5'd8,
      OP_SRL   = 5'd9,
      OP_SRA   = 5'd10,
      OP_AND   = 5'd11,
      OP_NAND  = 5'd12,
      OP_OR    = 5'd13,
      OP_XOR   = 5'd14,
      OP_MERGE = 5'd15,
      OP_SLT   = 5'd16,
      OP_SLTU  = 5'd17,
      OP_SLE   = 5'd18,
      OP_SLEU  = 5'd19,
      OP_SEQ   = 5'd20
   } alu_op_e;

   // offsets of the special source codes above the last general register
   localparam int SRC_OFS_ZERO  = 0;
   localparam int SRC_OFS_IMM   = 1;
   localparam int SRC_OFS_PAIR  = 2;
   localparam int SRC_OFS_IMM32 = 3;
   localparam int SRC_OFS_LD0   = 4;
   localparam int SRC_OFS_LD1   = 5;
   localparam int SRC_SPECIALS  = 6;

endpackage

// File: rtl/dsa_operand_sel.sv
module dsa_operand_sel
   import dsa_pkg::*;
#(
   parameter int DW   = 32,
   parameter int IW   = 16,
   parameter int NREG = 24,
   parameter int SELW = 5,
   parameter int SLOT = 0
) (
   input  logic [SELW-1:0]          sel,
   input  logic [NREG-1:0][DW-1:0]  rf,
   input  logic [IW-1:0]            imm0,
   input  logic [IW-1:0]            imm1,
   input  logic [DW-1:0]            load0,
   input  logic [DW-1:0]            load1,
   output logic [DW-1:0]            val
);

   localparam logic [SELW-1:0] C_IMM   = SELW'(NREG + SRC_OFS_IMM);
   localparam logic [SELW-1:0] C_PAIR  = SELW'(NREG + SRC_OFS_PAIR);
   localparam logic [SELW-1:0] C_IMM32 = SELW'(NREG + SRC_OFS_IMM32);
   localparam logic [SELW-1:0] C_LD0   = SELW'(NREG + SRC_OFS_LD0);
   localparam logic [SELW-1:0] C_LD1   = SELW'(NREG + SRC_OFS_LD1);

   logic [IW-1:0] own_imm;
   logic [IW-1:0] other_imm;

   generate
      if (SLOT == 0) begin : g_slot0
         assign own_imm   = imm0;
         assign other_imm = imm1;
      end else begin : g_slot1
         assign own_imm   = imm1;
         assign other_imm = imm0;
      end
   endgenerate

   always_comb begin
      val = '0;
      for (int i = 0; i < NREG; i++) begin
         if (sel == SELW'(i)) val = rf[i];
      end
      if (sel == C_IMM)   val = {{(DW-IW){own_imm[IW-1]}}, own_imm};
      if (sel == C_PAIR)  val = {{(DW-IW){other_imm[IW-1]}}, other_imm};
      if (sel == C_IMM32) val = {imm0, imm1};
      if (sel == C_LD0)   val = load0;
      if (sel == C_LD1)   val = load1;
   end

endmodule

// File: rtl/dsa_slot_alu.sv
module dsa_slot_alu
   import dsa_pkg::*;
#(
   parameter int DW = 32,
   parameter int IW = 16
) (
   input  alu_op_e        op,
   input  logic [DW-1:0]  x,
   input  logic [DW-1:0]  y,
   input  logic [IW-1:0]  imm,
   input  logic [DW-1:0]  carry_in,
   output logic [DW-1:0]  res,
   output logic [DW-1:0]  carry_out,
   output logic           carry_wr
);

   localparam int SHW = $clog2(DW);
   localparam int PW  = 2 * DW;

   logic [DW-1:0] sum, diff;
   logic [PW-1:0] prod_s, prod_u;
   logic [SHW-1:0] shamt;

   assign sum    = x + y;
   assign diff   = x - y;
   assign prod_s = {{DW{x[DW-1]}}, x} * {{DW{y[DW-1]}}, y};
   assign prod_u = {{DW{1'b0}}, x} * {{DW{1'b0}}, y};
   assign shamt  = y[SHW-1:0];

   // merge field decode from the slot immediate
   logic [5:0]     m_dst;
   logic [4:0]     m_width;
   logic [4:0]     m_src;
   logic [DW-1:0]  m_mask, m_field, m_res;

   assign m_dst   = imm[15:10];
   assign m_width = imm[9:5];
   assign m_src   = imm[4:0];
   assign m_mask  = (DW'(1) << m_width) - DW'(1);
   assign m_field = (y >> m_src) & m_mask;
   assign m_res   = (x & ~(m_mask << m_dst)) | (m_field << m_dst);

   function automatic logic [DW-1:0] lead_zeros(input logic [DW-1:0] v);
      logic [DW-1:0] n;
      n = DW'(DW);
      for (int i = 0; i < DW; i++) begin
         if (v[i]) n = DW'(DW - 1 - i);
      end
      return n;
   endfunction

   always_comb begin
      res       = '0;
      carry_out = '0;
      carry_wr  = 1'b0;
      unique case (op)
         OP_ADD: begin
            res       = sum;
            carry_out = DW'(sum < x);
            carry_wr  = 1'b1;
         end
         OP_ADDC: res = sum + carry_in;
         OP_SUB: begin
            res       = diff;
            carry_out = DW'(diff > x);
            carry_wr  = 1'b1;
         end
         OP_SUBB: res = diff - carry_in;
         OP_MUL: begin
            res       = prod_s[DW-1:0];
            carry_out = prod_s[PW-1:DW];
            carry_wr  = 1'b1;
         end
         OP_MULU: begin
            res       = prod_u[DW-1:0];
            carry_out = prod_u[PW-1:DW];
            carry_wr  = 1'b1;
         end
         OP_MULH:  res = carry_in;
         OP_CLZ:   res = lead_zeros(x);
         OP_SLL:   res = x << shamt;
         OP_SRL:   res = x >> shamt;
         OP_SRA:   res = DW'($signed(x) >>> shamt);
         OP_AND:   res = x & y;
         OP_NAND:  res = ~(x & y);
         OP_OR:    res = x | y;
         OP_XOR:   res = x ^ y;
         OP_MERGE: res = m_res;
         OP_SLT:   res = {DW{$signed(x) < $signed(y)}};
         OP_SLTU:  res = {DW{x < y}};
         OP_SLE:   res = {DW{$signed(x) <= $signed(y)}};
         OP_SLEU:  res = {DW{x <= y}};
         OP_SEQ:   res = {DW{x == y}};
         default:  res = '0;
      endcase
   end

   always_comb begin
      // R8
      cmp_form_chk: assert (!(op inside {OP_SLT, OP_SLTU, OP_SLE, OP_SLEU, OP_SEQ})
                            || res == '0 || res == '1);
      // R6
      clz_range_chk: assert (op != OP_CLZ || res <= DW'(DW));
      // R2
      addsub_flag_chk: assert (!(op inside {OP_ADD, OP_SUB}) || carry_out <= DW'(1));
   end

endmodule

// File: rtl/dsa_regfile.sv
module dsa_regfile #(
   parameter int DW   = 32,
   parameter int NREG = 24,
   parameter int SELW = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    issue,
   input  logic [SELW-1:0]         dst0,
   input  logic [SELW-1:0]         dst1,
   input  logic [DW-1:0]           wd0,
   input  logic [DW-1:0]           wd1,
   output logic [NREG-1:0][DW-1:0] rf
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rf <= '0;
      end else if (issue) begin
         for (int i = 0; i < NREG; i++) begin
            if (dst1 == SELW'(i))      rf[i] <= wd1;
            else if (dst0 == SELW'(i)) rf[i] <= wd0;
         end
      end
   end

   // R11
   no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue && (dst0 < SELW'(NREG) || dst1 < SELW'(NREG))) |=> $stable(rf));

   // R10
   slot1_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && dst0 == dst1 && dst1 < SELW'(NREG)) |=> rf[$past(dst1)] == $past(wd1));

endmodule

// File: rtl/dual_slot_alu.sv
module dual_slot_alu
   import dsa_pkg::*;
#(
   parameter int DW   = 32,
   parameter int IW   = 16,
   parameter int NREG = 24,
   parameter int SELW = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            issue,
   input  logic [4:0]      op0,
   input  logic [SELW-1:0] src0_a,
   input  logic [SELW-1:0] src0_b,
   input  logic [SELW-1:0] dst0,
   input  logic [4:0]      op1,
   input  logic [SELW-1:0] src1_a,
   input  logic [SELW-1:0] src1_b,
   input  logic [SELW-1:0] dst1,
   input  logic [IW-1:0]   imm0,
   input  logic [IW-1:0]   imm1,
   input  logic [DW-1:0]   load0,
   input  logic [DW-1:0]   load1,
   output logic [DW-1:0]   res0,
   output logic [DW-1:0]   res1,
   output logic [DW-1:0]   carry
);

   localparam int NSLOT = 2;

   generate
      if (DW != 2 * IW) begin : g_bad_width
         $error("data width must be twice the immediate width");
      end
      if (IW != 16) begin : g_bad_imm
         $error("merge decode expects a 16-bit immediate");
      end
      if (NREG + SRC_SPECIALS > (1 << SELW)) begin : g_bad_sel
         $error("selector too narrow for register count");
      end
   endgenerate

   logic [NSLOT-1:0][SELW-1:0] sel_a, sel_b, sel_d;
   alu_op_e                    op_v [NSLOT];
   logic [NSLOT-1:0][DW-1:0]   x_v, y_v, r_v, co_v, ci_v;
   logic [NSLOT-1:0][IW-1:0]   imm_v;
   logic [NSLOT-1:0]           cw_v;
   logic [NREG-1:0][DW-1:0]    rf;
   logic [DW-1:0]              carry_q, carry_d;
   logic [DW-1:0]              res0_q, res1_q;

   assign sel_a = {src1_a, src0_a};
   assign sel_b = {src1_b, src0_b};
   assign sel_d = {dst1, dst0};
   assign imm_v = {imm1, imm0};
   assign op_v[0] = alu_op_e'(op0);
   assign op_v[1] = alu_op_e'(op1);

   // carry chain: slot 1 sees what slot 0 produced this instruction
   assign ci_v[0] = carry_q;
   assign ci_v[1] = cw_v[0] ? co_v[0] : carry_q;
   assign carry_d = cw_v[1] ? co_v[1] : ci_v[1];

   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         dsa_operand_sel #(.DW(DW), .IW(IW), .NREG(NREG), .SELW(SELW), .SLOT(s)) u_sel_a (
            .sel(sel_a[s]), .rf(rf), .imm0(imm0), .imm1(imm1),
            .load0(load0), .load1(load1), .val(x_v[s])
         );
         dsa_operand_sel #(.DW(DW), .IW(IW), .NREG(NREG), .SELW(SELW), .SLOT(s)) u_sel_b (
            .sel(sel_b[s]), .rf(rf), .imm0(imm0), .imm1(imm1),
            .load0(load0), .load1(load1), .val(y_v[s])
         );
         dsa_slot_alu #(.DW(DW), .IW(IW)) u_alu (
            .op(op_v[s]), .x(x_v[s]), .y(y_v[s]), .imm(imm_v[s]),
            .carry_in(ci_v[s]), .res(r_v[s]), .carry_out(co_v[s]), .carry_wr(cw_v[s])
         );
      end
   endgenerate

   dsa_regfile #(.DW(DW), .NREG(NREG), .SELW(SELW)) u_rf (
      .clk(clk), .rst_n(rst_n), .issue(issue),
      .dst0(sel_d[0]), .dst1(sel_d[1]), .wd0(r_v[0]), .wd1(r_v[1]), .rf(rf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res0_q  <= '0;
         res1_q  <= '0;
         carry_q <= '0;
      end else if (issue) begin
         res0_q  <= r_v[0];
         res1_q  <= r_v[1];
         carry_q <= carry_d;
      end
   end

   assign res0  = res0_q;
   assign res1  = res1_q;
   assign carry = carry_q;

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> ($stable(res0) && $stable(res1) && $stable(carry)));

   // R3
   chain_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op1 inside {OP_ADDC, OP_SUBB}) |-> (op0 inside {OP_ADD, OP_SUB}));

   // R3
   chain_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op0 == OP_ADD && op1 == OP_ADDC) |=> carry <= DW'(1));

endmodule

// File: tb/dual_slot_alu_test.sv
module dual_slot_alu_test;
   localparam int CLK_PERIOD = 10;
   localparam int NR = 24;
   localparam logic [4:0] Z = 5'd24, IM = 5'd25, IP = 5'd26, I32 = 5'd27,
                          L0 = 5'd28, L1 = 5'd29, DROP = 5'd31;
   localparam logic [4:0] O_ADD = 0, O_ADDC = 1, O_SUB = 2, O_SUBB = 3, O_MUL = 4,
                          O_MULH = 5, O_MULU = 6, O_OR = 13, O_MERGE = 15;

   logic clk, rst_n, issue;
   logic [4:0] op0, src0_a, src0_b, dst0, op1, src1_a, src1_b, dst1;
   logic [15:0] imm0, imm1;
   logic [31:0] load0, load1, res0, res1, carry;

   int n_chk = 0, n_fail = 0;
   logic [31:0] mc;
   logic [31:0] shadow [NR];
   logic [31:0] vals [8];

   dual_slot_alu uut (
      .clk(clk), .rst_n(rst_n), .issue(issue),
      .op0(op0), .src0_a(src0_a), .src0_b(src0_b), .dst0(dst0),
      .op1(op1), .src1_a(src1_a), .src1_b(src1_b), .dst1(dst1),
      .imm0(imm0), .imm1(imm1), .load0(load0), .load1(load1),
      .res0(res0), .res1(res1), .carry(carry)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run(input logic [4:0] o0, a0, b0, d0, o1, a1, b1, d1,
                      input logic [15:0] i0, i1, input logic [31:0] l0, l1);
      @(negedge clk);
      op0 = o0; src0_a = a0; src0_b = b0; dst0 = d0;
      op1 = o1; src1_a = a1; src1_b = b1; dst1 = d1;
      imm0 = i0; imm1 = i1; load0 = l0; load1 = l1;
      issue = 1'b1;
      @(posedge clk);
      #1 issue = 1'b0;
   endtask

   task automatic read_reg(input int r, input string req);
      run(O_OR, 5'(r), Z, Z, O_OR, Z, Z, Z, 0, 0, 0, 0);
      chk(req, res0, shadow[r]);
   endtask

   function automatic logic [31:0] model(input logic [4:0] op, input logic [31:0] x, y,
                                         input logic [15:0] imm, input logic [31:0] cin,
                                         output logic cw, output logic [31:0] cout);
      longint sx, sy, ps;
      longint unsigned ux, uy, pu, mk, fld;
      logic [32:0] wide;
      int n;
      cw = 1'b0; cout = cin; model = 0;
      case (op)
         0: begin wide = {1'b0, x} + {1'b0, y}; model = wide[31:0]; cw = 1; cout = {31'b0, wide[32]}; end
         1: model = x + y + cin;
         2: begin model = x - y; cw = 1; cout = (y > x) ? 1 : 0; end
         3: model = x - y - cin;
         4: begin sx = $signed(x); sy = $signed(y); ps = sx * sy;
                  model = ps[31:0]; cw = 1; cout = ps[63:32]; end
         5: model = cin;
         6: begin ux = x; uy = y; pu = ux * uy; model = pu[31:0]; cw = 1; cout = pu[63:32]; end
         7: begin n = 0; for (int i = 31; i >= 0 && !x[i]; i--) n++; model = n; end
         8: model = x << y[4:0];
         9: model = x >> y[4:0];
         10: model = $unsigned($signed(x) >>> y[4:0]);
         11: model = x & y;
         12: model = ~(x & y);
         13: model = x | y;
         14: model = x ^ y;
         15: begin mk = (64'd1 << imm[9:5]) - 1; fld = (64'(y) >> imm[4:0]) & mk;
                   ux = (64'(x) & ~(mk << imm[15:10])) | (fld << imm[15:10]);
                   model = ux[31:0]; end
         16: model = ($signed(x) < $signed(y)) ? '1 : 0;
         17: model = (x < y) ? '1 : 0;
         18: model = ($signed(x) <= $signed(y)) ? '1 : 0;
         19: model = (x <= y) ? '1 : 0;
         20: model = (x == y) ? '1 : 0;
         default: model = 0;
      endcase
   endfunction

   function automatic string tag(input logic [4:0] op);
      case (op)
         0, 2: return "R2";
         4, 6: return "R4";
         8, 9, 10: return "R5";
         7, 11, 12, 13, 14: return "R6";
         15: return "R7";
         default: return "R8";
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic cw, cw2;
      logic [31:0] e, e2, co, co2;
      logic [4:0] sweep_ops [17];
      logic [15:0] mimms [6];
      sweep_ops = '{0, 2, 4, 6, 7, 8, 9, 10, 11, 12, 13, 14, 16, 17, 18, 19, 20};
      mimms = '{{6'd4, 5'd8, 5'd0}, {6'd0, 5'd16, 5'd16}, {6'd28, 5'd8, 5'd4},
                {6'd40, 5'd4, 5'd0}, {6'd0, 5'd0, 5'd3}, {6'd31, 5'd1, 5'd31}};
      vals = '{32'h0, 32'h1, 32'h2, 32'h7fffffff, 32'h80000000, 32'hffffffff,
               32'h12345678, 32'h21};
      for (int i = 0; i < NR; i++) shadow[i] = 0;
      mc = 0;
      rst_n = 1'b0; issue = 1'b0;
      op0 = 0; src0_a = Z; src0_b = Z; dst0 = Z; op1 = 0; src1_a = Z; src1_b = Z; dst1 = Z;
      imm0 = 0; imm1 = 0; load0 = 0; load1 = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk("R1 res0", res0, 0);
      chk("R1 res1", res1, 0);
      chk("R1 carry", carry, 0);
      for (int r = 0; r < NR; r++) read_reg(r, "R1 reg");

      // single-slot sweeps, slot 0, sources from the load registers
      foreach (sweep_ops[k]) begin
         for (int xi = 0; xi < 8; xi++) begin
            for (int yi = 0; yi < 8; yi++) begin
               e = model(sweep_ops[k], vals[xi], vals[yi], 0, mc, cw, co);
               run(sweep_ops[k], L0, L1, Z, O_OR, Z, Z, Z, 0, 0, vals[xi], vals[yi]);
               if (cw) mc = co;
               chk(tag(sweep_ops[k]), res0, e);
               chk({tag(sweep_ops[k]), " carry"}, carry, mc);
            end
         end
      end

      // R3 chained add/sub, R4 high word in slot 1, R2 slot 1 carry wins
      for (int xi = 0; xi < 8; xi++) begin
         for (int yi = 0; yi < 8; yi++) begin
            e = model(O_ADD, vals[xi], vals[yi], 0, mc, cw, co);
            e2 = model(O_ADDC, vals[yi], vals[xi], 0, co, cw2, co2);
            run(O_ADD, L0, L1, Z, O_ADDC, L1, L0, Z, 0, 0, vals[xi], vals[yi]);
            mc = co;
            chk("R3 addc", res1, e2);
            chk("R3 addc carry", carry, mc);
            e = model(O_SUB, vals[xi], vals[yi], 0, mc, cw, co);
            e2 = model(O_SUBB, vals[yi], vals[xi], 0, co, cw2, co2);
            run(O_SUB, L0, L1, Z, O_SUBB, L1, L0, Z, 0, 0, vals[xi], vals[yi]);
            mc = co;
            chk("R3 subb", res1, e2);
            chk("R3 subb carry", carry, mc);
            e = model(O_MUL, vals[xi], vals[yi], 0, mc, cw, co);
            run(O_MUL, L0, L1, Z, O_MULH, Z, Z, Z, 0, 0, vals[xi], vals[yi]);
            mc = co;
            chk("R4 mul low", res0, e);
            chk("R4 mulh slot1", res1, mc);
            run(O_MULH, Z, Z, Z, O_OR, Z, Z, Z, 0, 0, 0, 0);
            chk("R4 mulh slot0", res0, mc);
            e = model(O_MULU, vals[xi], vals[yi], 0, mc, cw, co);
            e2 = model(O_ADD, vals[yi], vals[xi], 0, co, cw2, co2);
            run(O_MULU, L0, L1, Z, O_ADD, L1, L0, Z, 0, 0, vals[xi], vals[yi]);
            mc = co2;
            chk("R2 slot1 carry wins", carry, mc);
         end
      end

      // R7 merge, each slot with its own immediate
      foreach (mimms[m]) begin
         for (int xi = 0; xi < 8; xi++) begin
            for (int yi = 0; yi < 8; yi++) begin
               e = model(O_MERGE, vals[xi], vals[yi], mimms[m], mc, cw, co);
               e2 = model(O_MERGE, vals[yi], vals[xi], mimms[5-m], mc, cw2, co2);
               run(O_MERGE, L0, L1, Z, O_MERGE, L1, L0, Z, mimms[m], mimms[5-m],
                   vals[xi], vals[yi]);
               chk("R7 slot0", res0, e);
               chk("R7 slot1", res1, e2);
            end
         end
      end

      // R9 source encodings
      run(O_OR, IM, Z, 5'd0, O_OR, IP, Z, 5'd1, 16'h8001, 16'h1234, 0, 0);
      shadow[0] = 32'hffff8001; shadow[1] = 32'hffff8001;
      chk("R9 own imm", res0, 32'hffff8001);
      chk("R9 pair imm", res1, 32'hffff8001);
      run(O_OR, IP, Z, Z, O_OR, IM, Z, Z, 16'h8001, 16'h1234, 0, 0);
      chk("R9 pair imm slot0", res0, 32'h00001234);
      chk("R9 own imm slot1", res1, 32'h00001234);
      run(O_OR, I32, Z, Z, O_OR, L1, Z, Z, 16'h8001, 16'h1234, 32'h5, 32'hcafef00d);
      chk("R9 imm32", res0, 32'h80011234);
      chk("R9 load1", res1, 32'hcafef00d);
      read_reg(0, "R9 reg0");
      read_reg(1, "R9 reg1");

      // R10 swap in one instruction, then collision
      run(O_OR, L0, Z, 5'd5, O_OR, L1, Z, 5'd6, 0, 0, 32'haaaa0001, 32'hbbbb0002);
      shadow[5] = 32'haaaa0001; shadow[6] = 32'hbbbb0002;
      run(O_OR, 5'd5, Z, 5'd6, O_OR, 5'd6, Z, 5'd5, 0, 0, 0, 0);
      chk("R10 swap res0", res0, 32'haaaa0001);
      chk("R10 swap res1", res1, 32'hbbbb0002);
      shadow[5] = 32'hbbbb0002; shadow[6] = 32'haaaa0001;
      read_reg(5, "R10 r5");
      read_reg(6, "R10 r6");
      run(O_OR, L0, Z, 5'd7, O_OR, L1, Z, 5'd7, 0, 0, 32'h11110000, 32'h22220000);
      shadow[7] = 32'h22220000;
      read_reg(7, "R10 collision");

      // R11 discarded destinations
      run(O_OR, L0, Z, Z, O_OR, L1, Z, DROP, 0, 0, 32'hdeadbeef, 32'hfeedface);
      chk("R11 result still out", res1, 32'hfeedface);
      for (int r = 0; r < NR; r++) read_reg(r, "R11 reg");

      // R12 idle cycles with changing inputs
      run(O_ADD, L0, L1, 5'd9, O_OR, L1, Z, Z, 0, 0, 32'hffffffff, 32'h3);
      shadow[9] = 32'h2; mc = 1;
      @(negedge clk);
      op0 = O_SUB; src0_a = L1; dst0 = 5'd9; op1 = O_MUL; src1_a = L0; src1_b = L1;
      load0 = 32'h777; load1 = 32'h99;
      repeat (3) @(posedge clk);
      #1;
      chk("R12 res0", res0, 32'h2);
      chk("R12 res1", res1, 32'h3);
      chk("R12 carry", carry, 1);
      read_reg(9, "R12 reg");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule